// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block holds the two interrupt flags that let the ports of a two-port, 2K x 8 shared memory signal each other. Each port owns one inbox word at the top of the 11-bit address space. The left port's inbox is 0x7FE and the right port's inbox is 0x7FF. When one port writes the other port's inbox, the other port's active-low interrupt output goes low. When the owning port reads its own inbox, its interrupt output goes high again.

The block only watches the access strobes of both ports. The data stored in the inbox words stays in the memory array next to it, where those words behave as ordinary cells. Each port also has a hold input, driven by the arbitration logic outside this block. While a port's hold is high, its accesses neither set nor clear any flag.

Both flags are registered. They change on the rising clock edge at which the qualifying access is present. Reset is synchronous and active high.

Top module: `mbx_irq_top`

## Requirements
- R1: While `rst` is high at a rising edge, both `l_irq_n` and `r_irq_n` are 1 after that edge.
- R2: A left write (`l_sel`=1, `l_wr`=1, `l_hold`=0) with `l_addr`=0x7FF drives `r_irq_n` to 0 after that edge.
- R3: A right read (`r_sel`=1, `r_rd`=1, `r_wr`=0, `r_hold`=0) with `r_addr`=0x7FF drives `r_irq_n` to 1 after that edge, unless R8 applies.
- R4: A right write (`r_sel`=1, `r_wr`=1, `r_hold`=0) with `r_addr`=0x7FE drives `l_irq_n` to 0 after that edge.
- R5: A left read (`l_sel`=1, `l_rd`=1, `l_wr`=0, `l_hold`=0) with `l_addr`=0x7FE drives `l_irq_n` to 1 after that edge, unless R8 applies.
- R6: While a port's hold is 1, that port's accesses neither set nor clear either flag.
- R7: Other accesses leave both flags unchanged. These are:
  - accesses with select low;
  - accesses to any address other than the inbox address in question;
  - a port writing its own inbox;
  - a port reading the other port's inbox;
  - a read with write also high, which counts as a write.
- R8: If a set and a clear of the same flag occur at the same edge, the flag ends set (interrupt output 0).
- R9: A flag keeps its value at every edge with neither a qualifying set nor a qualifying clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left port select |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_addr | input | 11 | Left address |
| l_hold | input | 1 | Left hold from arbitration; blocks flag actions |
| r_sel | input | 1 | Right port select |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_addr | input | 11 | Right address |
| r_hold | input | 1 | Right hold from arbitration; blocks flag actions |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
A set and a clear of the same flag can fall in the same cycle. For the right flag, this happens when the left port writes 0x7FF while the right port reads 0x7FF at the same edge. The left flag has the mirror case at 0x7FE. Directed cycles drive both ports together in exactly this way, both with hold low and with the hold of one port high. The random phase also produces many such coincidences. Each cycle's outputs are judged against a bench model in which the set takes priority over the clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int ADDR_W = 11;
    localparam int NPORT  = 2;

    typedef enum logic {
        PORT_L = 1'b0,
        PORT_R = 1'b1
    } port_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic              rd;
        logic              hold;
        logic [ADDR_W-1:0] addr;
    } port_req_t;

    typedef struct packed {
        logic set_peer;   // this port raises the other port's flag
        logic clr_own;    // this port acknowledges its own flag
    } mbx_evt_t;

    // Inbox of a port: right owns the top word, left the one below it.
    function automatic logic [ADDR_W-1:0] inbox_addr(port_e p);
        logic [ADDR_W-1:0] top;
        top = '1;
        return (p == PORT_R) ? top : top - 1'b1;
    endfunction

    function automatic port_e peer_of(port_e p);
        return (p == PORT_R) ? PORT_L : PORT_R;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter port_e SELF = PORT_L
) (
    input  port_req_t req,
    output mbx_evt_t  evt
);
    localparam port_e PEER = peer_of(SELF);
    localparam logic [ADDR_W-1:0] OWN_BOX  = inbox_addr(SELF);
    localparam logic [ADDR_W-1:0] PEER_BOX = inbox_addr(PEER);

    logic live;
    logic do_write;
    logic do_read;

    always_comb begin
        live     = req.sel && !req.hold;
        do_write = live && req.wr;
        do_read  = live && req.rd && !req.wr;
        evt.set_peer = do_write && (req.addr == PEER_BOX);
        evt.clr_own  = do_read  && (req.addr == OWN_BOX);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)        pend_q <= 1'b0;
        else if (set_i) pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end

    assign irq_n = !pend_q;

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> !irq_n);
    a_r3_clear_lands: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> irq_n);
    a_r9_hold_value: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(irq_n));
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_hold,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_hold,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    port_req_t        req [NPORT];
    mbx_evt_t         evt [NPORT];
    logic [NPORT-1:0] irq_n_v;

    always_comb begin
        req[PORT_L] = '{sel: l_sel, wr: l_wr, rd: l_rd, hold: l_hold, addr: l_addr};
        req[PORT_R] = '{sel: r_sel, wr: r_wr, rd: r_rd, hold: r_hold, addr: r_addr};
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam port_e SELF = port_e'(p);
        localparam port_e PEER = peer_of(SELF);

        mbx_decode #(.SELF(SELF)) u_dec (
            .req (req[p]),
            .evt (evt[p])
        );

        mbx_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (evt[PEER].set_peer),
            .clr_i (evt[p].clr_own),
            .irq_n (irq_n_v[p])
        );

        a_r6_hold_blocks: assert property (@(posedge clk) disable iff (rst)
            req[p].hold |-> (!evt[p].set_peer && !evt[p].clr_own));
        a_r7_write_not_read: assert property (@(posedge clk) disable iff (rst)
            req[p].wr |-> !evt[p].clr_own);
    end

    assign l_irq_n = irq_n_v[PORT_L];
    assign r_irq_n = irq_n_v[PORT_R];

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (l_irq_n && r_irq_n));
    a_r2_left_rings_right: assert property (@(posedge clk) disable iff (rst)
        (l_sel && l_wr && !l_hold && l_addr == 11'h7FF) |=> !r_irq_n);
    a_r4_right_rings_left: assert property (@(posedge clk) disable iff (rst)
        (r_sel && r_wr && !r_hold && r_addr == 11'h7FE) |=> !l_irq_n);
endmodule

// File: tb/mbx_irq_top_test.sv
module mbx_irq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst;
    logic        l_sel, l_wr, l_rd, l_hold;
    logic        r_sel, r_wr, r_rd, r_hold;
    logic [10:0] l_addr, r_addr;
    logic        l_irq_n, r_irq_n;

    int  checks = 0;
    int  errors = 0;
    bit  exp_l  = 1'b0;   // 1 = left flag pending
    bit  exp_r  = 1'b0;
    bit  done   = 1'b0;
    int  seed_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_irq_top uut (
        .clk(clk), .rst(rst),
        .l_sel(l_sel), .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_hold(l_hold),
        .r_sel(r_sel), .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_hold(r_hold),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    // A port writes the peer's inbox: it must be live and writing that word.
    function automatic bit rings(bit sel, bit wr, bit hold, logic [10:0] a, logic [10:0] box);
        return sel && wr && !hold && (a == box);
    endfunction

    // A port reads its own inbox: a read with write high counts as a write.
    function automatic bit acks(bit sel, bit wr, bit rd, bit hold, logic [10:0] a, logic [10:0] box);
        return sel && rd && !wr && !hold && (a == box);
    endfunction

    function automatic bit next_pend(bit cur, bit s, bit c);
        if (s) return 1'b1;
        if (c) return 1'b0;
        return cur;
    endfunction

    task automatic idle_inputs();
        l_sel = 0; l_wr = 0; l_rd = 0; l_hold = 0; l_addr = '0;
        r_sel = 0; r_wr = 0; r_rd = 0; r_hold = 0; r_addr = '0;
    endtask

    task automatic check(string tag, bit act_l, bit act_r);
        checks++;
        if (l_irq_n !== act_l || r_irq_n !== act_r) begin
            errors++;
            $display("FAIL %s: l_irq_n=%0b r_irq_n=%0b expected l_irq_n=%0b r_irq_n=%0b",
                     tag, l_irq_n, r_irq_n, act_l, act_r);
        end
    endtask

    // Apply one cycle of stimulus at the falling edge, update model, check after the rising edge.
    task automatic cycle(string tag,
                         bit ls, bit lw, bit lr, bit lh, logic [10:0] la,
                         bit rs, bit rw, bit rr, bit rh, logic [10:0] ra);
        bit set_l, clr_l, set_r, clr_r;
        @(negedge clk);
        l_sel = ls; l_wr = lw; l_rd = lr; l_hold = lh; l_addr = la;
        r_sel = rs; r_wr = rw; r_rd = rr; r_hold = rh; r_addr = ra;
        set_r = rings(ls, lw, lh, la, 11'h7FF);
        clr_r = acks(rs, rw, rr, rh, ra, 11'h7FF);
        set_l = rings(rs, rw, rh, ra, 11'h7FE);
        clr_l = acks(ls, lw, lr, lh, la, 11'h7FE);
        exp_r = next_pend(exp_r, set_r, clr_r);
        exp_l = next_pend(exp_l, set_l, clr_l);
        @(posedge clk);
        #(CLK_PERIOD/4);
        check(tag, !exp_l, !exp_r);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        seed_v = 32'h1d5a;
        void'($urandom(seed_v));
        idle_inputs();
        rst = 1;
        @(posedge clk);
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R1 reset", 1'b1, 1'b1);

        // R2 / R3 right flag
        @(negedge clk); rst = 0;
        cycle("R2 left write 7FF", 1,1,0,0,11'h7FF, 0,0,0,0,11'h000);
        cycle("R9 idle keeps",     0,0,0,0,11'h7FF, 0,0,0,0,11'h7FF);
        cycle("R7 right reads 7FE",0,0,0,0,11'h000, 1,0,1,0,11'h7FE);
        cycle("R3 right read 7FF", 0,0,0,0,11'h000, 1,0,1,0,11'h7FF);
        // R4 / R5 left flag
        cycle("R4 right write 7FE",0,0,0,0,11'h000, 1,1,0,0,11'h7FE);
        cycle("R7 left rd with wr",1,1,1,0,11'h7FE, 0,0,0,0,11'h000);
        cycle("R7 left reads 7FD", 1,0,1,0,11'h7FD, 0,0,0,0,11'h000);
        cycle("R5 left read 7FE",  1,0,1,0,11'h7FE, 0,0,0,0,11'h000);
        // R7 non-qualifying writes
        cycle("R7 left write own", 1,1,0,0,11'h7FE, 0,0,0,0,11'h000);
        cycle("R7 right write own",0,0,0,0,11'h000, 1,1,0,0,11'h7FF);
        cycle("R7 deselected",     0,1,0,0,11'h7FF, 0,1,0,0,11'h7FE);
        cycle("R7 other address",  1,1,0,0,11'h3FF, 1,1,0,0,11'h7FD);
        // R6 hold
        cycle("R6 left held write",1,1,0,1,11'h7FF, 0,0,0,0,11'h000);
        cycle("R6 right held write",0,0,0,0,11'h000, 1,1,0,1,11'h7FE);
        cycle("R2 set right again",1,1,0,0,11'h7FF, 1,1,0,0,11'h7FE);
        cycle("R6 right held read",0,0,0,0,11'h000, 1,0,1,1,11'h7FF);
        cycle("R6 left held read", 1,0,1,1,11'h7FE, 0,0,0,0,11'h000);
        // R8 coincidence: set and clear together
        cycle("R8 right set+clr",  1,1,0,0,11'h7FF, 1,0,1,0,11'h7FF);
        cycle("R8 left set+clr",   1,0,1,0,11'h7FE, 1,1,0,0,11'h7FE);
        cycle("R3 clear right",    0,0,0,0,11'h000, 1,0,1,0,11'h7FF);
        cycle("R6 held set, clr",  1,1,0,1,11'h7FF, 1,0,1,0,11'h7FF);
        cycle("R5 clear left",     1,0,1,0,11'h7FE, 0,0,0,0,11'h000);

        for (int i = 0; i < N_RANDOM; i++) begin
            logic [10:0] la, ra;
            int pick;
            pick = $urandom % 4;
            la = (pick == 0) ? 11'h7FE : (pick == 1) ? 11'h7FF : 11'($urandom);
            pick = $urandom % 4;
            ra = (pick == 0) ? 11'h7FE : (pick == 1) ? 11'h7FF : 11'($urandom);
            cycle("R9 random mix",
                  1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0, la,
                  1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0, ra);
        end

        @(negedge clk);
        rst = 1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        exp_l = 0; exp_r = 0;
        check("R1 reset again", 1'b1, 1'b1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule